// File: doc/BRIEF.md
# Packet-to-Escaped-Byte-Stream Encoder

This block turns a packetized stream into a flat byte stream for a serial transmitter. Each input beat is one data byte with three sideband fields: a start flag, an end flag and a channel number. From every beat the encoder builds a short output sequence. The sequence can hold a start marker, a channel-change marker with the new channel number, an end marker placed ahead of the last data byte, and the data byte itself. Any data or channel byte that collides with one of the four marker codes is escaped: the escape code is sent first, then the byte XORed with 0x20.

Both sides use a valid/ready handshake. A beat is accepted only when the encoder has no bytes left to send. The expanded sequence, between one and seven bytes long, then appears on the output one byte per taken transfer, starting in the cycle after acceptance. The encoder remembers the channel of the last accepted beat, so it can mark a change anywhere in a packet. After reset, the remembered channel is zero.

Top module: `pbe_encoder`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: A beat with `in_sop`=1 produces the start code 0x7A as its first output byte.
- R3: A beat with `in_eop`=1 produces the end code 0x7B placed directly ahead of its data byte, or ahead of that byte's escape code.
- R4: When `in_chan` differs from the channel of the previously accepted beat, the channel code 0x7C is emitted, followed by the channel number zero-extended to 8 bits. The remembered channel is 0 after reset, so a nonzero channel on the first beat is marked.
- R5: A data byte in the range 0x7A..0x7D is sent as the escape code 0x7D followed by the data XOR 0x20.
- R6: A channel number in the range 0x7A..0x7D that follows a 0x7C code is sent as 0x7D followed by the channel XOR 0x20.
- R7: Within one beat's sequence, the order is: start code, channel code and channel byte, end code, then the data byte (with its escape, if any).
- R8: The first byte of a beat's sequence is valid in the cycle after the beat is accepted. `in_ready` stays 0 until the last byte of that sequence has been taken.
- R9: While `out_valid`=1 and `out_ready`=0, `out_valid` and `out_data` hold their values into the next cycle.
- R10: A beat with no start, no end, an unchanged channel and a non-special data byte produces exactly one output byte, equal to the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Encoder can accept a beat |
| in_sop | input | 1 | Beat is the first of a packet |
| in_eop | input | 1 | Beat is the last of a packet |
| in_chan | input | CHAN_W | Channel number of the beat |
| in_data | input | DATA_W | Data byte of the beat |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Downstream takes the byte |
| out_data | output | DATA_W | Encoded output byte |

## Verification
A wrong remembered channel shows up as a missing or extra 0x7C code. It appears in the first beat after the corruption, one cycle after that beat is accepted. A wrong shift slot or remaining-byte count shows up in two ways: a byte out of order or dropped, or `in_ready` coming back too early or too late. Either is visible within one beat's sequence of at most seven transfers. Because every output byte is compared in order against a model queue, a single corrupted byte is reported at the transfer that carries it.

// File: rtl/pbe_pkg.sv
package pbe_pkg;
   localparam logic [7:0] CODE_SOP = 8'h7A;
   localparam logic [7:0] CODE_EOP = 8'h7B;
   localparam logic [7:0] CODE_CHN = 8'h7C;
   localparam logic [7:0] CODE_ESC = 8'h7D;
   localparam logic [7:0] ESC_FLIP = 8'h20;
   // start + channel code + escape + channel + end + escape + data
   localparam int unsigned SEQ_MAX = 7;
   localparam int unsigned LEN_W   = $clog2(SEQ_MAX + 1);

   function automatic logic is_special(input logic [7:0] b);
      return (b == CODE_SOP) || (b == CODE_EOP) || (b == CODE_CHN) || (b == CODE_ESC);
   endfunction
endpackage

// File: rtl/pbe_expand.sv
module pbe_expand
   import pbe_pkg::*;
#(
   parameter int unsigned CHAN_W = 8
)(
   input  logic                          sop,
   input  logic                          eop,
   input  logic [CHAN_W-1:0]             chan,
   input  logic [CHAN_W-1:0]             prev_chan,
   input  logic [7:0]                    data,
   output logic [SEQ_MAX-1:0][7:0]       seq,
   output logic [LEN_W-1:0]              seq_len
);
   logic [7:0] chan_byte;
   int unsigned n;

   always_comb begin
      chan_byte = '0;
      chan_byte[CHAN_W-1:0] = chan;
      seq = '0;
      n = 0;
      if (sop) begin
         seq[n] = CODE_SOP;
         n = n + 1;
      end
      if (chan != prev_chan) begin
         seq[n] = CODE_CHN;
         n = n + 1;
         if (is_special(chan_byte)) begin
            seq[n] = CODE_ESC;
            n = n + 1;
            seq[n] = chan_byte ^ ESC_FLIP;
         end else begin
            seq[n] = chan_byte;
         end
         n = n + 1;
      end
      if (eop) begin
         seq[n] = CODE_EOP;
         n = n + 1;
      end
      if (is_special(data)) begin
         seq[n] = CODE_ESC;
         n = n + 1;
         seq[n] = data ^ ESC_FLIP;
      end else begin
         seq[n] = data;
      end
      n = n + 1;
      seq_len = LEN_W'(n);
   end
endmodule

// File: rtl/pbe_track.sv
module pbe_track #(
   parameter int unsigned CHAN_W = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [CHAN_W-1:0] chan,
   output logic [CHAN_W-1:0] last_chan
);
   always_ff @(posedge clk) begin
      if (!rst_n)      last_chan <= '0;
      else if (accept) last_chan <= chan;
   end
endmodule

// File: rtl/pbe_shift.sv
module pbe_shift
   import pbe_pkg::*;
#(
   parameter int unsigned SLOTS = SEQ_MAX
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    load,
   input  logic [SLOTS-1:0][7:0]   seq,
   input  logic [LEN_W-1:0]        seq_len,
   input  logic                    take,
   output logic                    busy,
   output logic [7:0]              head
);
   logic [SLOTS-1:0][7:0] slot_q;
   logic [LEN_W-1:0]      rem_q;

   for (genvar i = 0; i < SLOTS; i++) begin : g_slot
      logic [7:0] next_byte;
      if (i == SLOTS - 1) begin : g_tail
         assign next_byte = '0;
      end else begin : g_body
         assign next_byte = slot_q[i+1];
      end
      always_ff @(posedge clk) begin
         if (!rst_n)    slot_q[i] <= '0;
         else if (load) slot_q[i] <= seq[i];
         else if (take) slot_q[i] <= next_byte;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    rem_q <= '0;
      else if (load) rem_q <= seq_len;
      else if (take) rem_q <= rem_q - 1'b1;
   end

   assign busy = (rem_q != '0);
   assign head = slot_q[0];
endmodule

// File: rtl/pbe_encoder.sv
module pbe_encoder
   import pbe_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned CHAN_W = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic              in_sop,
   input  logic              in_eop,
   input  logic [CHAN_W-1:0] in_chan,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_data
);
   if (DATA_W != 8) begin : g_bad_data
      $error("pbe_encoder: DATA_W must be 8");
   end
   if (CHAN_W < 1 || CHAN_W > 8) begin : g_bad_chan
      $error("pbe_encoder: CHAN_W must be 1..8");
   end

   logic                   busy;
   logic                   accept;
   logic                   take;
   logic [CHAN_W-1:0]      last_chan;
   logic [SEQ_MAX-1:0][7:0] seq;
   logic [LEN_W-1:0]       seq_len;
   logic [7:0]             head;

   assign in_ready  = !busy;
   assign accept    = in_valid && in_ready;
   assign out_valid = busy;
   assign take      = out_valid && out_ready;
   assign out_data  = DATA_W'(head);

   pbe_track #(.CHAN_W(CHAN_W)) u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .chan      (in_chan),
      .last_chan (last_chan)
   );

   pbe_expand #(.CHAN_W(CHAN_W)) u_expand (
      .sop       (in_sop),
      .eop       (in_eop),
      .chan      (in_chan),
      .prev_chan (last_chan),
      .data      (8'(in_data)),
      .seq       (seq),
      .seq_len   (seq_len)
   );

   pbe_shift #(.SLOTS(SEQ_MAX)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (accept),
      .seq     (seq),
      .seq_len (seq_len),
      .take    (take),
      .busy    (busy),
      .head    (head)
   );
endmodule

// File: rtl/pbe_checker.sv
module pbe_checker
   import pbe_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned CHAN_W = 8
)(
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_ready,
   input logic              in_sop,
   input logic [CHAN_W-1:0] in_chan,
   input logic              out_valid,
   input logic              out_ready,
   input logic [DATA_W-1:0] out_data
);
   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data)); // R9

   AST_ACCEPT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> out_valid && !in_ready); // R8

   AST_SOP_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready && in_sop |=> out_data == DATA_W'(CODE_SOP)); // R2

   AST_ESC_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_ready && out_data == DATA_W'(CODE_ESC)
      |=> out_valid && !is_special(8'(out_data))); // R5

   AST_CHN_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_ready && out_data == DATA_W'(CODE_CHN) |=> out_valid); // R4

   AST_EOP_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_ready && out_data == DATA_W'(CODE_EOP) |=> out_valid); // R3
endmodule

bind pbe_encoder pbe_checker #(.DATA_W(DATA_W), .CHAN_W(CHAN_W)) u_pbe_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .in_sop    (in_sop),
   .in_chan   (in_chan),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_data  (out_data)
);

// File: tb/tb_pbe_encoder.sv
module tb_pbe_encoder;
   localparam int CLK_PERIOD = 10;
   localparam int DATA_W = 8;
   localparam int CHAN_W = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic              in_ready;
   logic              in_sop = 1'b0;
   logic              in_eop = 1'b0;
   logic [CHAN_W-1:0] in_chan = '0;
   logic [DATA_W-1:0] in_data = '0;
   logic              out_valid;
   logic              out_ready = 1'b0;
   logic [DATA_W-1:0] out_data;

   int checks = 0;
   int errors = 0;
   int ready_pct = 100;
   logic [7:0]        exp_q[$];
   string             tag_q[$];
   logic [CHAN_W-1:0] model_chan = '0;
   logic              hold_pend = 1'b0;
   logic [7:0]        hold_byte = '0;
   bit                done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pbe_encoder #(.DATA_W(DATA_W), .CHAN_W(CHAN_W)) dut (.*);

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic bit special(input logic [7:0] b);
      return b >= 8'h7A && b <= 8'h7D;
   endfunction

   function automatic void push(input logic [7:0] b, input string t, input string ovr);
      exp_q.push_back(b);
      tag_q.push_back(ovr != "" ? ovr : t);
   endfunction

   function automatic void model(input bit s, input bit e, input logic [CHAN_W-1:0] c,
                                 input logic [7:0] d, input string ovr);
      logic [7:0] cb;
      cb = 8'(c);
      if (s) push(8'h7A, "R2", ovr);
      if (c != model_chan) begin
         push(8'h7C, "R4", ovr);
         if (special(cb)) begin
            push(8'h7D, "R6", ovr);
            push(cb ^ 8'h20, "R6", ovr);
         end else push(cb, "R4", ovr);
      end
      if (e) push(8'h7B, "R3", ovr);
      if (special(d)) begin
         push(8'h7D, "R5", ovr);
         push(d ^ 8'h20, "R5", ovr);
      end else push(d, (s || e || c != model_chan) ? "R4" : "R10", ovr);
      model_chan = c;
   endfunction

   task automatic send(input bit s, input bit e, input logic [CHAN_W-1:0] c,
                       input logic [7:0] d, input string ovr);
      @(negedge clk);
      in_valid = 1'b1; in_sop = s; in_eop = e; in_chan = c; in_data = d;
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      model(s, e, c, d, ovr);
      @(negedge clk);
      check(out_valid === 1'b1 && in_ready === 1'b0, "R8",
            {out_valid, in_ready}, 2'b10);
      in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
   endtask

   // output monitor: decide ready, then compare the byte taken at the next edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (hold_pend)
            check(out_valid === 1'b1 && out_data === hold_byte, "R9", out_data, hold_byte);
         out_ready = (($urandom % 100) < ready_pct);
         hold_pend = out_valid && !out_ready;
         hold_byte = out_data;
         if (out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R8", out_data, 0);
            end else begin
               logic [7:0] eb;
               string t;
               eb = exp_q.pop_front();
               t = tag_q.pop_front();
               check(out_data === eb, t, out_data, eb);
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(out_valid === 1'b0 && in_ready === 1'b1, "R1", {out_valid, in_ready}, 2'b01);
      rst_n = 1'b1;
      // first beat after reset with nonzero channel
      send(1'b1, 1'b0, 8'h03, 8'h41, "R4");
      send(1'b0, 1'b0, 8'h03, 8'h42, "");
      send(1'b0, 1'b0, 8'h03, 8'h7A, "");
      send(1'b0, 1'b0, 8'h05, 8'h7D, "");
      send(1'b0, 1'b1, 8'h05, 8'h10, "");
      // special channel numbers
      send(1'b1, 1'b0, 8'h7C, 8'h00, "");
      send(1'b0, 1'b1, 8'h7A, 8'h7B, "");
      // every insertion on one beat, under full back-pressure mix
      ready_pct = 30;
      send(1'b1, 1'b1, 8'h7D, 8'h7C, "R7");
      send(1'b0, 1'b0, 8'h7D, 8'h55, "R10");
      // random traffic
      ready_pct = 60;
      for (int i = 0; i < 400; i++) begin
         logic [CHAN_W-1:0] c;
         logic [7:0] d;
         c = ($urandom % 4 == 0) ? CHAN_W'(8'h7A + ($urandom % 4)) : CHAN_W'($urandom % 3);
         d = ($urandom % 3 == 0) ? 8'h7A + 8'($urandom % 4) : 8'($urandom);
         if (i % 50 == 0) ready_pct = 20 + int'($urandom % 81);
         send(($urandom % 5) == 0, ($urandom % 5) == 0, c, d, "");
         if ($urandom % 4 == 0) repeat ($urandom % 4) @(negedge clk);
      end
      ready_pct = 100;
      while (exp_q.size() != 0 || out_valid) @(negedge clk);
      @(negedge clk);
      check(exp_q.size() == 0 && in_ready === 1'b1, "R8", exp_q.size(), 0);
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule